// File: doc/BRIEF.md
# Carry-Save Fused Multiply-Accumulate Unit

This block keeps a running total of products for filter-style inner loops. On every cycle that the valid strobe is high, it takes two unsigned operands and multiplies them. The product is not resolved into a single binary number. It stays as a pair of carry-save vectors, one holding partial sums and one holding carries. A single row of 3:2 compressors merges those two vectors with the stored total. One carry-propagate adder then resolves the result, and that result is written back into the accumulator register.

A synchronous clear restarts the total. When the clear and the valid strobe are high in the same cycle, the new total is just the current product, so a fresh dot product can start with no idle cycle. When neither is high, the total is held. The arithmetic wraps at the accumulator width.

Top module: `mac_cs_accum`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `acc` becomes zero on that edge, whatever the other inputs are.
- R2: When `in_valid` is 1 and `clr` is 0 at a rising edge, `acc` becomes (previous `acc` + `op_a` * `op_b`) mod 2^ACC_W.
- R3: When `in_valid` is 0 and `clr` is 0, `acc` keeps its value, whatever the operands are.
- R4: When `clr` is 1 and `in_valid` is 0, `acc` becomes zero on that edge.
- R5: When `clr` is 1 and `in_valid` is 1, `acc` becomes `op_a` * `op_b`, and the old total is discarded.
- R6: The total wraps modulo 2^ACC_W (2^24 by default) with no saturation. For example, repeated 255*255 products roll over past 0xFFFFFF.
- R7: The two carry-save product vectors always add, modulo 2^ACC_W, to the exact product `op_a` * `op_b`. This holds for operand extremes such as 0, 1 and all-ones.
- R8: An accepted operand pair is reflected in `acc` right after the next rising edge, with exactly one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous restart of the running total |
| in_valid | input | 1 | Operand pair on `op_a`/`op_b` is to be accumulated |
| op_a | input | OP_W (8) | Unsigned multiplicand |
| op_b | input | OP_W (8) | Unsigned multiplier |
| acc | output | ACC_W (24) | Running total of accepted products |

## Verification
The total feeds back into every later result. A wrong carry-save vector, a dropped compressor carry or a bad hold or clear decision therefore leaves a lasting offset in `acc` one edge after the faulty cycle, and every later compare shows that offset until the next clear. The bench checks `acc` against a behavioural total after every edge, so such a fault shows up within one cycle of the stimulus that exposes it. Runs of all-ones operands drive the total across the wrap point, which exposes carries lost at the top bit.

// File: rtl/mac_cs_pkg.sv
// Shared definitions for the carry-save multiply-accumulate unit.
// Assumes: operands are unsigned; ACC_W >= 2*OP_W.
package mac_cs_pkg;
    localparam int unsigned OP_W_DEF  = 8;
    localparam int unsigned ACC_W_DEF = 24;

    // Update applied to the accumulator on a clock edge
    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_ADD  = 2'd1,
        ACC_ZERO = 2'd2,
        ACC_LOAD = 2'd3
    } acc_op_e;
endpackage

// File: rtl/csa_row.sv
// Row of W full adders used as 3:2 compressors.
// Reduces three vectors to a sum vector and a carry vector. The carry vector
// is already shifted one place up; the top carry is dropped (modulo 2^W).
// Assumes: W >= 2.
module csa_row #(
    parameter int unsigned W = 24
) (
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    input  logic [W-1:0] in_z,
    output logic [W-1:0] out_s,
    output logic [W-1:0] out_c
);
    logic [W-1:0] maj;

    // Bitwise sum and majority of the three inputs
    always_comb begin
        out_s = in_x ^ in_y ^ in_z;
        maj   = (in_x & in_y) | (in_x & in_z) | (in_y & in_z);
        out_c = {maj[W-2:0], 1'b0};
    end
endmodule

// File: rtl/cs_product.sv
// Combinational unsigned multiplier that leaves its result in carry-save
// form. Each partial product is the multiplicand ANDed with one multiplier
// bit and shifted into place. A linear chain of 3:2 rows reduces them to two
// vectors whose sum mod 2^W is the product.
// Assumes: OP_W >= 2, W >= 2*OP_W.
module cs_product #(
    parameter int unsigned OP_W = 8,
    parameter int unsigned W    = 24
) (
    input  logic [OP_W-1:0] mcand,
    input  logic [OP_W-1:0] mplier,
    output logic [W-1:0]    vec_s,
    output logic [W-1:0]    vec_c
);
    localparam int unsigned STAGES = OP_W - 1;

    logic [W-1:0] pp    [OP_W];
    logic [W-1:0] red_s [STAGES];
    logic [W-1:0] red_c [STAGES];

    // Partial-product generation: AND with each multiplier bit, then shift
    for (genvar i = 0; i < OP_W; i++) begin : g_pp
        always_comb pp[i] = mplier[i] ? (W'(mcand) << i) : '0;
    end

    // The first two partial products seed the carry-save pair
    always_comb begin
        red_s[0] = pp[0];
        red_c[0] = pp[1];
    end

    // Each later partial product is folded in by one compressor row
    for (genvar k = 2; k < OP_W; k++) begin : g_red
        csa_row #(.W(W)) u_row (
            .in_x  (red_s[k-2]),
            .in_y  (red_c[k-2]),
            .in_z  (pp[k]),
            .out_s (red_s[k-1]),
            .out_c (red_c[k-1])
        );
    end

    // Final pair of the chain leaves the module unresolved
    always_comb begin
        vec_s = red_s[STAGES-1];
        vec_c = red_c[STAGES-1];
    end
endmodule

// File: rtl/mac_cs_accum.sv
// Multiply-accumulate unit with a fused final addition.
// The product stays in carry-save form. One 3:2 row merges it with the stored
// total (or with zero on a restart), and a single carry-propagate adder
// resolves the result into the accumulator register.
// Assumes: unsigned operands, wrap-around arithmetic, synchronous active-low
// reset, clear with valid loads the bare product.
module mac_cs_accum
    import mac_cs_pkg::*;
#(
    parameter int unsigned OP_W  = OP_W_DEF,
    parameter int unsigned ACC_W = ACC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    output logic [ACC_W-1:0] acc
);
    acc_op_e          upd;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_feed;
    logic [ACC_W-1:0] prod_sum;
    logic [ACC_W-1:0] prod_cry;
    logic [ACC_W-1:0] mrg_s;
    logic [ACC_W-1:0] mrg_c;
    logic [ACC_W-1:0] total;
    logic [ACC_W-1:0] acc_d;

    // Decode the control strobes into one update kind
    always_comb begin
        unique case ({clr, in_valid})
            2'b01:   upd = ACC_ADD;
            2'b10:   upd = ACC_ZERO;
            2'b11:   upd = ACC_LOAD;
            default: upd = ACC_HOLD;
        endcase
    end

    cs_product #(.OP_W(OP_W), .W(ACC_W)) u_prod (
        .mcand  (op_a),
        .mplier (op_b),
        .vec_s  (prod_sum),
        .vec_c  (prod_cry)
    );

    // Restart drops the old total from the compressor input
    always_comb acc_feed = (upd == ACC_LOAD) ? '0 : acc_q;

    csa_row #(.W(ACC_W)) u_merge (
        .in_x  (prod_sum),
        .in_y  (prod_cry),
        .in_z  (acc_feed),
        .out_s (mrg_s),
        .out_c (mrg_c)
    );

    // Single shared carry-propagate adder
    always_comb total = mrg_s + mrg_c;

    // Next-value selection for the accumulator
    always_comb begin
        unique case (upd)
            ACC_ADD, ACC_LOAD: acc_d = total;
            ACC_ZERO:          acc_d = '0;
            default:           acc_d = acc_q;
        endcase
    end

    // Accumulator register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    always_comb acc = acc_q;
endmodule

// File: rtl/mac_cs_accum_chk.sv
// Property checker for mac_cs_accum, attached by bind. It watches the ports
// and the carry-save product pair. It drives nothing.
module mac_cs_accum_chk #(
    parameter int unsigned OP_W  = 8,
    parameter int unsigned ACC_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             in_valid,
    input logic [OP_W-1:0]  op_a,
    input logic [OP_W-1:0]  op_b,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] prod_sum,
    input logic [ACC_W-1:0] prod_cry
);
    // R2, R6, R8: accepted pair adds into the total one edge later, wrapping
    a_r2_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr) |=> acc == ACC_W'($past(acc)
                                  + ACC_W'($past(op_a)) * ACC_W'($past(op_b))));

    // R3: idle cycle keeps the total
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clr) |=> $stable(acc));

    // R4: clear alone empties the total
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !in_valid) |=> acc == '0);

    // R5: clear with valid loads only the current product
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && in_valid) |=> acc == ACC_W'($past(op_a)) * ACC_W'($past(op_b)));

    // R7: carry-save pair always resolves to the exact product
    a_r7_cs_pair: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ACC_W'(prod_sum + prod_cry) == ACC_W'(op_a) * ACC_W'(op_b));
endmodule

bind mac_cs_accum mac_cs_accum_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .acc      (acc),
    .prod_sum (prod_sum),
    .prod_cry (prod_cry)
);

// File: tb/mac_cs_accum_bench.sv
// Bench: a behavioural running total is compared with acc on every cycle.
module mac_cs_accum_bench;
    localparam int unsigned OP_W   = 8;
    localparam int unsigned ACC_W  = 24;
    localparam time         T_CLK  = 10ns;
    localparam longint      MODV   = 64'd1 << ACC_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             clr;
    logic             in_valid;
    logic [OP_W-1:0]  op_a;
    logic [OP_W-1:0]  op_b;
    logic [ACC_W-1:0] acc;

    int     total = 0;
    int     bad   = 0;
    longint model = 0;
    bit     done  = 1'b0;

    mac_cs_accum #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mac_cs_accum (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .acc(acc)
    );

    always #(T_CLK/2) clk = ~clk;

    // Compare the output with the model value
    task automatic check(string tag);
        total++;
        if (longint'(acc) != model) begin
            bad++;
            $display("FAIL %s: acc=%0h expected=%0h", tag, acc, model);
        end
    endtask

    // Check the previous cycle, then drive one cycle and advance the model
    task automatic step(bit c, bit v, int a, int b, string tag);
        check(tag);
        clr = c; in_valid = v; op_a = OP_W'(a); op_b = OP_W'(b);
        if (c && v)      model = (longint'(a) * b) % MODV;
        else if (c)      model = 0;
        else if (v)      model = (model + longint'(a) * b) % MODV;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; clr = 1'b0; in_valid = 1'b1; op_a = 8'hFF; op_b = 8'hFF;
        repeat (3) @(negedge clk);
        model = 0;
        check("R1 reset state");
        rst_n = 1'b1;
        // R8: single product visible after one edge; R7 extremes
        step(0, 1, 7, 9, "R1 reset state");
        step(0, 1, 0, 255, "R8 one-cycle latency");
        step(0, 1, 255, 1, "R7 zero operand");
        step(0, 1, 1, 1, "R7 unit operands");
        step(0, 1, 255, 255, "R7 unit operands");
        // R3: idle with changing operands
        step(0, 0, 200, 200, "R7 all-ones product");
        step(0, 0, 13, 77, "R3 hold");
        step(0, 1, 3, 4, "R3 hold");
        // R4 clear alone, R5 clear with valid
        step(1, 0, 99, 99, "R2 accumulate");
        step(0, 1, 10, 10, "R4 clear");
        step(1, 1, 17, 23, "R2 accumulate");
        step(0, 1, 2, 2, "R5 restart loads product");
        // R1: reset mid-run
        step(0, 0, 0, 0, "R2 accumulate");
        rst_n = 1'b0; in_valid = 1'b1; op_a = 8'd50; op_b = 8'd50; model = 0;
        @(negedge clk);
        check("R1 mid-run reset");
        rst_n = 1'b1;
        // R6: wrap with all-ones products
        step(1, 1, 255, 255, "R1 mid-run reset");
        for (int i = 0; i < 300; i++) step(0, 1, 255, 255, "R6 wrap");
        // R2: random mix
        for (int i = 0; i < 2000; i++) begin
            int unsigned r = $urandom;
            step(r[3:0] == 0, r[5:4] != 0, int'($urandom % 256), int'($urandom % 256),
                 "R2 random stream");
        end
        check("R2 random stream");
        done = 1'b1;
    end

    // Watchdog and single summary line
    initial begin
        fork
            wait (done);
            begin
                #(T_CLK * 100000);
                total++; bad++;
                $display("FAIL watchdog: acc=%0h expected=finish", acc);
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule